// File: doc/BRIEF.md
# Compare-Match Timer Channel Array

A small memory-mapped timer peripheral that groups several compare-match channels behind a single register bus. One shared start register holds a run bit for each channel. Each channel has three registers: a control/status register, an up-counter and a compare register.

While its run bit is set, a channel's counter advances once per prescaled tick. When the counter equals the compare value at a tick, the counter returns to zero instead of incrementing. The match period is therefore the compare value plus one ticks. At that point a sticky match flag is set, and if the channel's interrupt enable is on, its interrupt line goes high. The line stays high until software clears the flag.

A parameter builds each channel in one of two forms, narrow (16 bit) or wide (32 bit). The form sets the counter width, the spacing of the registers, the position of the flag bit and the position of the enable bit. Software selects the prescaler ratio per channel. The usual settings are a control value of 0x43 on a narrow channel (divide by 512) and 0x01A4 on a wide channel (divide by 8).

Top module: `mt_timer_array`

## Requirements
- R1: After reset the run bits are 0, every control/status register reads 0, every counter reads 0, every compare register reads all ones (0xFFFF narrow, 0xFFFFFFFF wide) and every interrupt line is low.
- R2: Register map, byte addresses:
  - The start register is at 0x00, and bit n is the run bit of channel n.
  - Channel n starts at 0x10 + 0x10*n.
  - Within a channel, control/status, counter and compare have indices 0, 1 and 2. The byte offset is the index shifted left by 1 on a narrow channel and by 2 on a wide channel.
  - Channel 0 is narrow and channel 1 is wide.
- R3: While a channel's run bit is 0, its counter holds its value. Setting the bit again resumes counting from that value.
- R4: Control bits [1:0] select the prescale ratio 8 << (2*sel), giving 8, 32, 128 or 512. The prescaler is free running and starts at reset release. A channel counts on the clock edges where the number of edges since reset release, taken modulo the ratio, equals the ratio minus one.
- R5: On a tick where the counter equals the compare value, the counter becomes 0. On any other tick it increments.
- R6: A tick that takes the counter from the compare value to 0 sets a sticky match flag. The flag is bit 7 on a narrow channel and bit 15 on a wide channel.
- R7: A wide channel sets flag bit 14 when a tick takes its counter from all ones to 0 without a compare match. A narrow channel has no such flag.
- R8: Writing control/status with a flag bit at 0 clears that flag, and writing it at 1 leaves the flag unchanged. A flag set event in the same cycle wins over the clear. The other writable bits (narrow [6:0], wide [13:0]) read back as written.
- R9: A channel's interrupt line is high exactly when its match flag and its enable bit are both set. The enable bit is bit 6 on a narrow channel and bit 5 on a wide channel.
- R10: A write to the compare register applies from the next cycle. If the value written is below the current count, the counter runs on to its full-width wrap before it can match.
- R11: A bus write to a counter sets it to the written value, truncated to the channel width. This write takes priority over a count in the same cycle and suppresses that cycle's match or wrap flag.
- R12: Read data appears on rdata_o in the clock cycle after a read request and is 0 in every other cycle. Writes to unmapped addresses change nothing, and reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus request valid |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 2 | Interrupt line per channel |

## Verification
The bench drives the counters into the corner cases where an off-by-one hides:
- A counter sitting exactly on its compare value. A design that incremented past it, or cleared one tick early, would show a period of the compare value or of the compare value plus two.
- A compare value written below the running count. A design that compared with "greater or equal" would match at once instead of after the full-width wrap, and a wide channel would then miss its wrap flag.
- A counter write landing on a tick, and a flag clear landing on a flag set. If the wrong side won either collision, the count would be lost or the interrupt would be dropped.
- A write of 1 to a flag bit. A design that treated writes as plain stores would raise a flag by software.
- Unmapped addresses in the gaps between narrow registers. Sloppy decoding would alias these gaps onto real registers.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int DIV_BASE_LOG2 = 3;   // smallest ratio: 8
  localparam int DIV_STEP_LOG2 = 2;   // each select step: x4
  localparam int REG_CTL = 0;
  localparam int REG_CNT = 1;
  localparam int REG_CMP = 2;

  function automatic int reg_off(input bit wide, input int idx);
    return wide ? (idx << 2) : (idx << 1);
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int NUM_TAPS = 4,
  localparam int PW = mt_pkg::DIV_BASE_LOG2 + mt_pkg::DIV_STEP_LOG2 * (NUM_TAPS - 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tick_o
);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int LB = mt_pkg::DIV_BASE_LOG2 + mt_pkg::DIV_STEP_LOG2 * k;
    assign tick_o[k] = &pre_q[LB-1:0];
  end
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
  parameter bit WIDE     = 1'b0,
  parameter int NUM_TAPS = 4,
  localparam int CW = WIDE ? 32 : 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [NUM_TAPS-1:0] ticks_i,
  input  logic                ctl_we_i,
  input  logic                cnt_we_i,
  input  logic                cmp_we_i,
  input  logic [CW-1:0]       wdata_i,
  output logic [15:0]         ctl_o,
  output logic [31:0]         cnt_o,
  output logic [31:0]         cmp_o,
  output logic                irq_o
);
  localparam int          SEL_W    = $clog2(NUM_TAPS);
  localparam int          MF_BIT   = WIDE ? 15 : 7;
  localparam int          WF_BIT   = 14;
  localparam int          IE_BIT   = WIDE ? 5 : 6;
  localparam logic [15:0] CFG_MASK = WIDE ? 16'h3FFF : 16'h007F;

  logic [CW-1:0] cnt_q, cmp_q;
  logic [15:0]   cfg_q;
  logic          mflag_q, wflag;
  logic          tick, hit, at_cmp, match_set;

  assign tick      = ticks_i[cfg_q[SEL_W-1:0]];
  assign hit       = run_i & tick;
  assign at_cmp    = (cnt_q == cmp_q);
  assign match_set = hit & at_cmp & ~cnt_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (hit)      cnt_q <= at_cmp ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '1;
    else if (cmp_we_i) cmp_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (ctl_we_i) cfg_q <= wdata_i[15:0] & CFG_MASK;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mflag_q <= 1'b0;
    else         mflag_q <= match_set | (mflag_q & ~(ctl_we_i & ~wdata_i[MF_BIT]));
  end

  if (WIDE) begin : g_wrap
    logic wflag_q, wrap_set;
    assign wrap_set = hit & ~at_cmp & (&cnt_q) & ~cnt_we_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wflag_q <= 1'b0;
      else         wflag_q <= wrap_set | (wflag_q & ~(ctl_we_i & ~wdata_i[WF_BIT]));
    end
    assign wflag = wflag_q;
  end else begin : g_nowrap
    assign wflag = 1'b0;
  end

  assign ctl_o = cfg_q | (16'(mflag_q) << MF_BIT) | (16'(wflag) << WF_BIT);
  assign cnt_o = 32'(cnt_q);
  assign cmp_o = 32'(cmp_q);
  assign irq_o = mflag_q & cfg_q[IE_BIT];
endmodule

// File: rtl/mt_timer_array.sv
module mt_timer_array #(
  parameter int               NUM_CH     = 2,
  parameter logic [NUM_CH-1:0] WIDE_MASK = 2'b10,
  parameter int               ADDR_W     = 8,
  parameter int               START_ADDR = 'h00,
  parameter int               CH_BASE    = 'h10,
  parameter int               CH_SPAN    = 'h10,
  parameter int               NUM_TAPS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_TAPS-1:0]          ticks;
  logic [NUM_CH-1:0]            run_q;
  logic                         sel_start;
  logic [NUM_CH-1:0]            sel_ctl, sel_cnt, sel_cmp;
  logic [NUM_CH-1:0]            ch_ctl_we, ch_cnt_we, ch_cmp_we;
  logic [NUM_CH-1:0][15:0]      ch_ctl;
  logic [NUM_CH-1:0][31:0]      ch_cnt, ch_cmp;
  logic [31:0]                  rd_mux, rdata_q;

  mt_prescaler #(.NUM_TAPS(NUM_TAPS)) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (ticks)
  );

  assign sel_start = valid_i && (addr_i == ADDR_W'(START_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (sel_start && write_i) run_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit W    = WIDE_MASK[i];
    localparam int CWI  = W ? 32 : 16;
    localparam int BASE = CH_BASE + i * CH_SPAN;

    assign sel_ctl[i] = valid_i && (addr_i == ADDR_W'(BASE + mt_pkg::reg_off(W, mt_pkg::REG_CTL)));
    assign sel_cnt[i] = valid_i && (addr_i == ADDR_W'(BASE + mt_pkg::reg_off(W, mt_pkg::REG_CNT)));
    assign sel_cmp[i] = valid_i && (addr_i == ADDR_W'(BASE + mt_pkg::reg_off(W, mt_pkg::REG_CMP)));

    assign ch_ctl_we[i] = sel_ctl[i] & write_i;
    assign ch_cnt_we[i] = sel_cnt[i] & write_i;
    assign ch_cmp_we[i] = sel_cmp[i] & write_i;

    mt_channel #(.WIDE(W), .NUM_TAPS(NUM_TAPS)) u_channel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[i]),
      .ticks_i  (ticks),
      .ctl_we_i (ch_ctl_we[i]),
      .cnt_we_i (ch_cnt_we[i]),
      .cmp_we_i (ch_cmp_we[i]),
      .wdata_i  (wdata_i[CWI-1:0]),
      .ctl_o    (ch_ctl[i]),
      .cnt_o    (ch_cnt[i]),
      .cmp_o    (ch_cmp[i]),
      .irq_o    (irq_o[i])
    );
  end

  always_comb begin
    rd_mux = sel_start ? 32'(run_q) : '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ctl[i]) rd_mux |= 32'(ch_ctl[i]);
      if (sel_cnt[i]) rd_mux |= ch_cnt[i];
      if (sel_cmp[i]) rd_mux |= ch_cmp[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (valid_i && !write_i) ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mt_timer_array_chk.sv
module mt_timer_array_chk #(
  parameter int                NUM_CH    = 2,
  parameter logic [NUM_CH-1:0] WIDE_MASK = 2'b10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [31:0]              wdata_i,
  input logic [NUM_CH-1:0]        run_q,
  input logic [NUM_CH-1:0]        ch_cnt_we,
  input logic [NUM_CH-1:0]        ch_ctl_we,
  input logic [NUM_CH-1:0][15:0]  ch_ctl,
  input logic [NUM_CH-1:0][31:0]  ch_cnt,
  input logic [NUM_CH-1:0][31:0]  ch_cmp
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam int          MF    = WIDE_MASK[i] ? 15 : 7;
    localparam logic [31:0] CMASK = WIDE_MASK[i] ? 32'hFFFF_FFFF : 32'h0000_FFFF;

    // R3
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[i] && !ch_cnt_we[i]) |=> (ch_cnt[i] == $past(ch_cnt[i])));

    // R5
    no_pass_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q[i] && !ch_cnt_we[i] && ch_cnt[i] == ch_cmp[i])
        |=> (ch_cnt[i] == 32'd0 || ch_cnt[i] == $past(ch_cnt[i])));

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_ctl[i][MF] && !ch_ctl_we[i]) |=> ch_ctl[i][MF]);

    // R11
    cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_cnt_we[i] |=> (ch_cnt[i] == ($past(wdata_i) & CMASK)));
  end
endmodule

bind mt_timer_array mt_timer_array_chk #(
  .NUM_CH    (NUM_CH),
  .WIDE_MASK (WIDE_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdata_i   (wdata_i),
  .run_q     (run_q),
  .ch_cnt_we (ch_cnt_we),
  .ch_ctl_we (ch_ctl_we),
  .ch_ctl    (ch_ctl),
  .ch_cnt    (ch_cnt),
  .ch_cmp    (ch_cmp)
);

// File: tb/mt_timer_array_bench.sv
module mt_timer_array_bench;
  localparam int       CLK_PERIOD = 10;
  localparam int       NUM_CH     = 2;
  localparam bit [1:0] WIDE       = 2'b10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        valid_i = 1'b0, write_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_timer_array u_mt_timer_array (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int    vectors = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  longint unsigned m_cnt [NUM_CH];
  longint unsigned m_cmp [NUM_CH];
  int unsigned     m_cfg [NUM_CH];
  bit              m_mf  [NUM_CH];
  bit              m_wf  [NUM_CH];
  int unsigned     m_run;
  int              pre;
  longint unsigned exp_rd;
  bit [1:0]        exp_irq;

  function automatic longint unsigned cmax(int c);
    return WIDE[c] ? 64'hFFFF_FFFF : 64'hFFFF;
  endfunction
  function automatic int fbit(int c);   return WIDE[c] ? 15 : 7; endfunction
  function automatic int iebit(int c);  return WIDE[c] ? 5 : 6;  endfunction
  function automatic int unsigned cfgmask(int c); return WIDE[c] ? 'h3FFF : 'h7F; endfunction
  function automatic int addr_of(int c, int idx);
    return 'h10 + 'h10 * c + (WIDE[c] ? (idx << 2) : (idx << 1));
  endfunction

  function automatic longint unsigned ctl_val(int c);
    return longint'(m_cfg[c]) | (longint'(m_mf[c]) << fbit(c)) | (longint'(m_wf[c]) << 14);
  endfunction

  function automatic longint unsigned rd_val(int a);
    if (a == 0) return longint'(m_run);
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == addr_of(c, 0)) return ctl_val(c);
      if (a == addr_of(c, 1)) return m_cnt[c];
      if (a == addr_of(c, 2)) return m_cmp[c];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++) begin
        m_cnt[c] = 0; m_cmp[c] = cmax(c); m_cfg[c] = 0; m_mf[c] = 0; m_wf[c] = 0;
      end
      m_run = 0; pre = 0; exp_rd = 0; exp_irq = '0;
    end else begin
      bit wr;
      wr = valid_i && write_i;
      exp_rd = (valid_i && !write_i) ? rd_val(int'(addr_i)) : 0;
      for (int c = 0; c < NUM_CH; c++) begin
        int d; bit tick, ms, ws; longint unsigned ncnt;
        d = 8 << (2 * (m_cfg[c] & 3));
        tick = (pre % d) == d - 1;
        ms = 0; ws = 0; ncnt = m_cnt[c];
        if (wr && int'(addr_i) == addr_of(c, 1)) ncnt = longint'(wdata_i) & cmax(c);
        else if (m_run[c] && tick) begin
          if (m_cnt[c] == m_cmp[c]) begin ncnt = 0; ms = 1; end
          else begin
            if (m_cnt[c] == cmax(c)) ws = WIDE[c];
            ncnt = (m_cnt[c] + 1) & cmax(c);
          end
        end
        if (wr && int'(addr_i) == addr_of(c, 0)) begin
          m_mf[c] = m_mf[c] & wdata_i[fbit(c)];
          m_wf[c] = m_wf[c] & wdata_i[14];
          m_cfg[c] = wdata_i & cfgmask(c);
        end
        m_mf[c] = m_mf[c] | ms;
        m_wf[c] = m_wf[c] | ws;
        if (wr && int'(addr_i) == addr_of(c, 2)) m_cmp[c] = longint'(wdata_i) & cmax(c);
        m_cnt[c] = ncnt;
      end
      if (wr && addr_i == 8'h00) m_run = wdata_i & 32'h3;
      pre = (pre + 1) % 512;
      for (int c = 0; c < NUM_CH; c++) exp_irq[c] = m_mf[c] && m_cfg[c][iebit(c)];
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      vectors++;
      if (rdata_o !== exp_rd[31:0]) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata_o, exp_rd[31:0], $time);
      end
      vectors++;
      if (irq_o !== exp_irq) begin
        fails++;
        $display("FAIL %s irq actual=%b expected=%b t=%0t", cur_req, irq_o, exp_irq, $time);
      end
    end
  end

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    valid_i = 1'b1; write_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk);
    valid_i = 1'b0; write_i = 1'b0;
  endtask

  task automatic bus_rd(input int a);
    @(negedge clk);
    valid_i = 1'b1; write_i = 1'b0; addr_i = 8'(a);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1 reset readback
    cur_req = "R1";
    bus_rd('h00);
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < 3; k++) bus_rd(addr_of(c, k));
    // R2 map
    cur_req = "R2";
    bus_wr('h14, 32'h0000_1234);
    bus_wr('h18, 32'hDEAD_BEEF);
    bus_wr('h12, 32'h0000_00AB);
    bus_wr('h24, 32'h0000_0077);
    bus_rd('h14); bus_rd('h18); bus_rd('h12); bus_rd('h24);
    // R4 R5 R6 R9 wide channel /8, period 6
    cur_req = "R5";
    bus_wr('h24, 32'h0);
    bus_wr('h28, 32'd5);
    bus_wr('h20, 32'h0000_01A4);
    bus_wr('h00, 32'h2);
    for (int k = 0; k < 20; k++) begin idle(5); bus_rd('h24); end
    cur_req = "R6";
    bus_rd('h20);
    // R8 flag writes
    cur_req = "R8";
    bus_wr('h20, 32'h0000_C1A4);
    bus_rd('h20);
    bus_wr('h20, 32'h0000_01A4);
    bus_rd('h20);
    idle(40);
    bus_wr('h20, 32'h0000_0125);
    bus_rd('h20);
    // R3 halt and resume
    cur_req = "R3";
    bus_wr('h00, 32'h0);
    bus_rd('h24); idle(60); bus_rd('h24);
    bus_wr('h00, 32'h2);
    idle(30); bus_rd('h24);
    // R9 enable off keeps flag but lowers line
    cur_req = "R9";
    bus_wr('h20, 32'h0000_8184);
    idle(30);
    bus_wr('h20, 32'h0000_01A4);
    idle(30);
    bus_wr('h20, 32'h0);
    idle(10);
    // R4 narrow channel /512, period 3
    cur_req = "R4";
    bus_wr('h12, 32'h0);
    bus_wr('h14, 32'd2);
    bus_wr('h10, 32'h0000_0043);
    bus_wr('h00, 32'h3);
    for (int k = 0; k < 40; k++) begin idle(50); bus_rd('h12); end
    bus_rd('h10);
    bus_wr('h10, 32'h0000_0041);
    for (int k = 0; k < 10; k++) begin idle(20); bus_rd('h12); end
    // R10 R7 compare below count, wide wraps with flag
    cur_req = "R7";
    bus_wr('h20, 32'h0000_0020);
    bus_wr('h24, 32'hFFFF_FFF0);
    bus_wr('h28, 32'd3);
    for (int k = 0; k < 30; k++) begin idle(8); bus_rd('h24); end
    bus_rd('h20);
    cur_req = "R10";
    bus_wr('h10, 32'h0000_0040);
    bus_wr('h12, 32'h0000_FFF8);
    bus_wr('h14, 32'd1);
    for (int k = 0; k < 30; k++) begin idle(8); bus_rd('h12); end
    bus_rd('h10);
    // R11 counter writes while running
    cur_req = "R11";
    for (int k = 0; k < 24; k++) begin
      bus_wr('h24, 32'(k * 3));
      bus_wr('h12, 32'h0001_0000 | 32'(k));
      bus_rd('h24); bus_rd('h12);
    end
    // R12 unmapped
    cur_req = "R12";
    bus_wr('h02, 32'hFFFF_FFFF);
    bus_wr('h16, 32'hFFFF_FFFF);
    bus_wr('h22, 32'hFFFF_FFFF);
    bus_wr('h2C, 32'hFFFF_FFFF);
    bus_wr('h30, 32'hFFFF_FFFF);
    bus_rd('h02); bus_rd('h16); bus_rd('h1A); bus_rd('h2C); bus_rd('h30); bus_rd('h00);
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < 3; k++) bus_rd(addr_of(c, k));
    // mixed traffic
    cur_req = "R5";
    for (int k = 0; k < 600; k++) begin
      int c, r;
      logic [31:0] d;
      c = int'($urandom_range(0, NUM_CH - 1));
      r = int'($urandom_range(0, 2));
      d = $urandom;
      if (r == 0) d = d & 32'hFFFF_FFFC;
      if (r == 2) d = d & 32'h3F;
      if ($urandom_range(0, 3) == 0) bus_wr(addr_of(c, r), d);
      else if ($urandom_range(0, 7) == 0) bus_wr('h00, d);
      else bus_rd(addr_of(c, int'($urandom_range(0, 2))));
    end
    idle(5);
    finish_run();
  end
endmodule